// File: doc/BRIEF.md
# Pipelined Late-Write Static Memory with Write Buffer Bypass

This block is a synchronous single-port word memory. The clock edge samples the address, a synchronous select, a global write strobe, one write strobe per byte lane and a sleep request. A read is sampled on one edge. Its word is loaded into an output register on the next edge and is driven from there. A write is sampled with its address and lane strobes only. Its data word arrives on the data input one edge later. The data then waits in an internal write buffer. The array receives it at the edge where the data of the next write arrives. If a read falls on an address that is still waiting in the buffer, the buffered lanes are forwarded, so the read always sees the newest value.

The data word is split into byte lanes. The default is four lanes of 9 bits. Lane i occupies bits i*LANE_W through i*LANE_W+LANE_W-1, so bits 0-8 are lane 0 and bits 27-35 are lane 3. The output drive qualifier is combinational in the output-enable input. The sleep input freezes the command path without losing stored or buffered data.

Top module: `lw_sram`

## Requirements
- R1: While reset is asserted and directly after it is released, `dq_oe` is 0.
- R2: A read command (`sel`=1, `wr`=0, `sleep`=0) sampled at edge t makes `dq_o` carry the word at `addr`, with `dq_oe`=1 when `oe`=1, from edge t+1 until edge t+2.
- R3: A write command sampled at edge t takes its data word from `din` at edge t+1, and later reads of that address return it. `dq_oe` is 0 in the output slot of a write command.
- R4: Only lanes whose `lane_we` bit is 1 are modified by a write. Bit i of `lane_we` guards data bits i*LANE_W .. i*LANE_W+LANE_W-1.
- R5: A read sampled on the edge that delivers a write's data, or sampled any time before the next write's data arrives, returns the buffered lanes of that write merged with the stored lanes.
- R6: A buffered write is committed to the array when the next write's data arrives, and later reads of either address return the correct merged words.
- R7: A cycle with `sel`=0 starts nothing: contents are unchanged whatever `wr`, `lane_we`, `addr` and `din` carry, and `dq_oe` is 0 in that cycle's output slot.
- R8: `dq_oe` follows `oe` combinationally within a cycle: it is 0 whenever `oe` is 0.
- R9: While `sleep`=1, commands are ignored and `dq_oe` is 0 in their output slots. Stored and buffered data are kept. The data word of a write accepted just before sleep is still captured. Commands are accepted again at the first edge with `sleep`=0.
- R10: With `wr`=0, a selected cycle is a read whatever `lane_we` carries, and it writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sel | input | 1 | Synchronous select; 0 makes the cycle a no-op |
| wr | input | 1 | Global write strobe; 1 = write, 0 = read |
| lane_we | input | LANES | Per-lane write strobes |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, one cycle behind its command |
| sleep | input | 1 | Synchronous power-down request |
| oe | input | 1 | Asynchronous output enable |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Drive qualifier for `dq_o` (0 = high impedance) |

## Verification
The hardest situation to reach is a read that must mix lanes from the write buffer with lanes from the array. This happens while a partial-lane write is still uncommitted, and also while a second write has just pushed an earlier one into the array in the same edge as the read. The stimulus builds this with short scripted command strings. A partial-lane write is followed at once by a read of the same address that carries the write data on `din`. Chains of writes to neighbouring addresses are interleaved with reads of the older ones. Sleep is entered exactly on the data cycle of a pending write, to show that the data is still captured.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } lw_op_e;

   function automatic lw_op_e lw_decode(input logic sel, input logic wr, input logic sleep);
      if (!sel || sleep) return OP_NONE;
      else if (wr)       return OP_WRITE;
      else               return OP_READ;
   endfunction

endpackage

// File: rtl/lw_array.sv
module lw_array #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANES * LANE_W,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANES-1:0]  wlanes,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   // one storage slice per lane so each lane has an independent write strobe
   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wlanes[gl]) begin
            store[waddr] <= wdata[gl*LANE_W +: LANE_W];
         end
      end

      assign rdata[gl*LANE_W +: LANE_W] = store[raddr];
   end

endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   // write command accepted this edge
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [LANES-1:0]  push_lanes,
   // late data for the write accepted on the previous edge
   input  logic [DATA_W-1:0] din,
   // lookup port
   input  logic [ADDR_W-1:0] look_addr,
   output logic [LANES-1:0]  hit_lanes,
   output logic [DATA_W-1:0] hit_data,
   // commit port into the array
   output logic              cmt_en,
   output logic [ADDR_W-1:0] cmt_addr,
   output logic [LANES-1:0]  cmt_lanes,
   output logic [DATA_W-1:0] cmt_data
);

   // stage 0: write waiting for its data word
   logic              wait_v;
   logic [ADDR_W-1:0] wait_addr;
   logic [LANES-1:0]  wait_lanes;
   // stage 1: complete write waiting for commit
   logic              held_v;
   logic [ADDR_W-1:0] held_addr;
   logic [LANES-1:0]  held_lanes;
   logic [DATA_W-1:0] held_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_v     <= 1'b0;
         wait_addr  <= '0;
         wait_lanes <= '0;
         held_v     <= 1'b0;
         held_addr  <= '0;
         held_lanes <= '0;
      end else begin
         wait_v <= push;
         if (push) begin
            wait_addr  <= push_addr;
            wait_lanes <= push_lanes;
         end
         if (wait_v) begin
            held_v     <= 1'b1;
            held_addr  <= wait_addr;
            held_lanes <= wait_lanes;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wait_v) held_data <= din;
   end

   // the older entry leaves for the array on the edge its successor completes
   assign cmt_en    = wait_v && held_v;
   assign cmt_addr  = held_addr;
   assign cmt_lanes = held_lanes;
   assign cmt_data  = held_data;

   logic addr_match;
   assign addr_match = held_v && (held_addr == look_addr);
   assign hit_lanes  = addr_match ? held_lanes : '0;
   assign hit_data   = held_data;

endmodule

// File: rtl/lw_merge.sv
module lw_merge #(
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic [DATA_W-1:0] arr_d,
   input  logic [DATA_W-1:0] buf_d,
   input  logic [LANES-1:0]  pick_buf,
   output logic [DATA_W-1:0] y
);

   for (genvar gl = 0; gl < LANES; gl++) begin : g_mux
      assign y[gl*LANE_W +: LANE_W] = pick_buf[gl] ? buf_d[gl*LANE_W +: LANE_W]
                                                   : arr_d[gl*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
   import lw_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9,
   parameter int LANES  = 4,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [LANES-1:0]  lane_we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              sleep,
   input  logic              oe,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("lw_sram: ADDR_W must lie in 1..16");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("lw_sram: LANE_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("lw_sram: LANES must be at least 1");
   end

   lw_op_e op;
   logic   take_wr, take_rd;

   assign op      = lw_decode(sel, wr, sleep);
   assign take_wr = (op == OP_WRITE);
   assign take_rd = (op == OP_READ);

   // read address stage
   logic              rd_v;
   logic [ADDR_W-1:0] rd_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_v    <= 1'b0;
         rd_addr <= '0;
      end else begin
         rd_v <= take_rd;
         if (take_rd) rd_addr <= addr;
      end
   end

   logic [LANES-1:0]  hit_lanes;
   logic [DATA_W-1:0] hit_data;
   logic              cmt_en;
   logic [ADDR_W-1:0] cmt_addr;
   logic [LANES-1:0]  cmt_lanes;
   logic [DATA_W-1:0] cmt_data;
   logic [DATA_W-1:0] arr_data;
   logic [DATA_W-1:0] merged;

   lw_wbuf #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take_wr),
      .push_addr (addr),
      .push_lanes(lane_we),
      .din       (din),
      .look_addr (rd_addr),
      .hit_lanes (hit_lanes),
      .hit_data  (hit_data),
      .cmt_en    (cmt_en),
      .cmt_addr  (cmt_addr),
      .cmt_lanes (cmt_lanes),
      .cmt_data  (cmt_data)
   );

   lw_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .clk   (clk),
      .we    (cmt_en),
      .waddr (cmt_addr),
      .wlanes(cmt_lanes),
      .wdata (cmt_data),
      .raddr (rd_addr),
      .rdata (arr_data)
   );

   lw_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
      .arr_d   (arr_data),
      .buf_d   (hit_data),
      .pick_buf(hit_lanes),
      .y       (merged)
   );

   // output register stage
   logic              out_v;
   logic [DATA_W-1:0] out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_v <= 1'b0;
         out_q <= '0;
      end else begin
         out_v <= rd_v;
         if (rd_v) out_q <= merged;
      end
   end

   assign dq_o  = out_q;
   assign dq_oe = out_v && oe;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic sel,
   input logic wr,
   input logic sleep,
   input logic oe,
   input logic dq_oe
);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !dq_oe);                                     // R1

   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !wr && !sleep) |=> ##1 (dq_oe == oe));               // R2

   AST_WRITE_SLOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && !sleep) |=> ##1 !dq_oe);                       // R3

   AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> ##1 !dq_oe);                                        // R7

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !dq_oe);                                             // R8

   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ##1 !dq_oe);                                       // R9

endmodule

bind lw_sram lw_sram_chk u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .sel  (sel),
   .wr   (wr),
   .sleep(sleep),
   .oe   (oe),
   .dq_oe(dq_oe)
);

// File: tb/sim_lw_sram.sv
module sim_lw_sram;
   localparam int AW = 8;
   localparam int LW = 9;
   localparam int NL = 4;
   localparam int DW = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0, wr = 1'b0, sleep = 1'b0, oe = 1'b1;
   logic [NL-1:0] lane_we = '0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dq_o;
   logic          dq_oe;

   always #5 clk = ~clk;

   lw_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .lane_we(lane_we),
      .addr(addr), .din(din), .sleep(sleep), .oe(oe), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   logic [DW-1:0] mdl [DEPTH];
   bit            pend_v = 0;
   logic [AW-1:0] pend_a;
   logic [NL-1:0] pend_l;
   bit            exp_v = 0;
   bit            exp_drv;
   logic [DW-1:0] exp_d;
   string         exp_tag;

   function automatic logic [DW-1:0] pat(input int a);
      logic [7:0] b = a[7:0];
      return {4'hA, b, ~b, b ^ 8'h5A, b + 8'd3};
   endfunction

   function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old_w,
                                              input logic [DW-1:0] new_w,
                                              input logic [NL-1:0] ln);
      logic [DW-1:0] r = old_w;
      for (int i = 0; i < NL; i++)
         if (ln[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
      return r;
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock of stimulus; checks the output slot of the previous command
   task automatic step(input string tag, input bit s, input bit w, input logic [NL-1:0] l,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input bit slp);
      bit            n_drv;
      logic [DW-1:0] n_d;
      sel = s; wr = w; lane_we = l; addr = a; din = d; sleep = slp;
      if (pend_v) mdl[pend_a] = lane_mix(mdl[pend_a], d, pend_l);
      pend_v = s && !slp && w;
      pend_a = a;
      pend_l = l;
      n_drv  = s && !slp && !w;
      n_d    = mdl[a];
      @(posedge clk);
      @(negedge clk);
      if (exp_v) begin
         check(exp_tag, "dq_oe", {35'd0, dq_oe}, {35'd0, exp_drv && oe});
         if (exp_drv) check(exp_tag, "dq_o", dq_o, exp_d);
      end
      exp_v   = 1;
      exp_drv = n_drv;
      exp_d   = n_d;
      exp_tag = tag;
   endtask

   task automatic t_reset;
      check("R1", "dq_oe in reset", {35'd0, dq_oe}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1", "dq_oe after release", {35'd0, dq_oe}, '0);
   endtask

   task automatic t_fill;
      for (int a = 0; a < DEPTH; a++)
         step("R3", 1, 1, 4'hF, a[AW-1:0], pat(a - 1), 0);
      step("R3", 1, 0, 4'h0, 8'd255, pat(DEPTH - 1), 0);
      step("R2", 1, 0, 4'h0, 8'd0, '0, 0);
      step("R2", 1, 0, 4'h0, 8'd100, '0, 0);
      step("R2", 1, 0, 4'h0, 8'd1, '0, 0);
      step("R2", 0, 0, 4'h0, 8'd0, '0, 0);
   endtask

   task automatic t_lanes;
      step("R4", 1, 1, 4'b0101, 8'd5, '0, 0);
      step("R4", 1, 1, 4'b1111, 8'd200, 36'h1_2345_6789, 0);
      step("R4", 1, 0, 4'b0000, 8'd5, 36'hF_EDCB_A987, 0);
      step("R4", 1, 0, 4'b0000, 8'd200, '0, 0);
      step("R4", 1, 1, 4'b1000, 8'd6, '0, 0);
      step("R4", 1, 1, 4'b0010, 8'd7, 36'h9_9999_9999, 0);
      step("R4", 1, 0, 4'b0000, 8'd6, 36'h6_6666_6666, 0);
      step("R4", 1, 0, 4'b0000, 8'd7, '0, 0);
   endtask

   task automatic t_forward;
      step("R5", 1, 1, 4'b1010, 8'd80, '0, 0);
      step("R5", 1, 0, 4'b0000, 8'd80, 36'h5_A5A5_A5A5, 0);
      step("R5", 1, 0, 4'b0000, 8'd80, '0, 0);
      step("R5", 1, 0, 4'b0000, 8'd81, '0, 0);
      step("R5", 1, 0, 4'b0000, 8'd80, '0, 0);
   endtask

   task automatic t_commit;
      step("R6", 1, 1, 4'hF, 8'd90, '0, 0);
      step("R6", 1, 1, 4'hF, 8'd91, 36'h0_9090_9090, 0);
      step("R6", 1, 0, 4'h0, 8'd90, 36'h0_9191_9191, 0);
      step("R6", 1, 0, 4'h0, 8'd91, '0, 0);
      step("R6", 1, 1, 4'b0011, 8'd92, '0, 0);
      step("R6", 1, 1, 4'b1100, 8'd90, 36'h3_3333_3333, 0);
      step("R6", 1, 0, 4'h0, 8'd92, 36'hC_CCCC_CCCC, 0);
      step("R6", 1, 0, 4'h0, 8'd90, '0, 0);
      step("R6", 1, 0, 4'h0, 8'd93, '0, 0);
   endtask

   task automatic t_deselect;
      step("R7", 0, 1, 4'hF, 8'd60, 36'hD_EADB_EEF0, 0);
      step("R7", 0, 1, 4'hF, 8'd61, 36'hB_ADBA_DBAD, 0);
      step("R7", 0, 0, 4'h0, 8'd60, 36'h1_1111_1111, 0);
      step("R7", 1, 0, 4'h0, 8'd60, '0, 0);
      step("R7", 1, 0, 4'h0, 8'd61, '0, 0);
      step("R7", 0, 0, 4'h0, 8'd0, '0, 0);
   endtask

   task automatic t_oe;
      step("R8", 1, 0, 4'h0, 8'd33, '0, 0);
      step("R8", 0, 0, 4'h0, 8'd0, '0, 0);
      oe = 1'b0;
      #1;
      check("R8", "dq_oe with oe low", {35'd0, dq_oe}, '0);
      oe = 1'b1;
      #1;
      check("R8", "dq_oe with oe high", {35'd0, dq_oe}, 36'd1);
   endtask

   task automatic t_sleep;
      step("R9", 1, 1, 4'hF, 8'd40, '0, 0);
      step("R9", 1, 1, 4'hF, 8'd41, 36'h4_0404_0404, 1);
      step("R9", 1, 0, 4'h0, 8'd40, 36'h7_7777_7777, 1);
      step("R9", 1, 0, 4'h0, 8'd40, '0, 0);
      step("R9", 1, 0, 4'h0, 8'd41, '0, 0);
      step("R9", 0, 0, 4'h0, 8'd0, '0, 0);
   endtask

   task automatic t_no_global;
      step("R10", 1, 0, 4'hF, 8'd70, 36'hE_EEEE_EEEE, 0);
      step("R10", 1, 0, 4'hF, 8'd71, 36'hF_FFFF_FFFF, 0);
      step("R10", 1, 0, 4'h0, 8'd70, '0, 0);
      step("R10", 1, 0, 4'h0, 8'd71, '0, 0);
      step("R10", 0, 0, 4'h0, 8'd0, '0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_fill();
      t_lanes();
      t_forward();
      t_commit();
      t_deselect();
      t_oe();
      t_sleep();
      t_no_global();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule